// File: doc/BRIEF.md
# Partial-Width Integer Register File

This block holds sixteen 64-bit integer registers and serves two read ports and one write port each cycle. Every port names a register, an access width and, for the byte width, a high-byte select. An access can cover the whole 64-bit register or only its lowest 32, 16 or 8 bits. On the first four registers the high-byte select picks bits 15:8 as an 8-bit register of its own.

Reads are combinational and zero-extend the selected view to 64 bits. A write lands on the rising clock edge. A 32-bit write clears the upper half of its register. A 16-bit or 8-bit write changes only the bytes it addresses. A read that names the register being written in the same cycle returns the value from before the write. Register 4 carries the stack pointer by convention, but the file handles it exactly like every other register.

Width code on every port: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.

Top module: `regfile_pw`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears to zero, even if a write is requested in that cycle.
- R2: A write with width code 3 replaces all 64 bits. A read with width code 3 returns all 64 bits.
- R3: A write with width code 2 stores `wr_data[31:0]` in bits 31:0 and sets bits 63:32 of the register to zero.
- R4: A write with width code 1 stores `wr_data[15:0]` in bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with width code 0 and the high-byte select low stores `wr_data[7:0]` in bits 7:0 and leaves bits 63:8 unchanged.
- R6: On registers 0 to 3, width code 0 with the high-byte select high addresses bits 15:8. A write stores `wr_data[7:0]` there and keeps every other bit. A read returns bits 15:8 in `data[7:0]`.
- R7: The high-byte select has no effect on registers 4 to 15, where the plain low byte is used instead. It also has no effect with any width code other than 0.
- R8: Read data is zero-extended: the bits above the selected view are 0.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R10: Register 4 is written and read like any other register.
- R11: The two read ports are independent of each other. With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register written |
| wr_size | input | 2 | Write width code |
| wr_hi | input | 1 | High-byte select for the write |
| wr_data | input | 64 | Write data, right-aligned |
| ra_idx | input | 4 | Register read on port A |
| ra_size | input | 2 | Port A width code |
| ra_hi | input | 1 | Port A high-byte select |
| ra_data | output | 64 | Port A data, zero-extended |
| rb_idx | input | 4 | Register read on port B |
| rb_size | input | 2 | Port B width code |
| rb_hi | input | 1 | Port B high-byte select |
| rb_data | output | 64 | Port B data, zero-extended |

## Verification
The merge properties compare the value written against a full-width read of the same register on port A. They assume that port A names that register at width code 3, with the high-byte select low, in the cycle of the write and in the cycle after it. The property is vacuous in any other cycle. The stability property assumes that the port A controls are the only thing besides a write that can change port A data. The stimulus therefore often repeats the write index on port A at full width and holds the port controls across idle cycles, so these antecedents occur often. It also sets the high-byte select on every width and every index, because the design must accept such combinations and ignore them.

// File: rtl/regfile_pw.sv
module regfile_pw #(
  parameter int REGS    = 16,
  parameter int HI_REGS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(REGS)-1:0] wr_idx,
  input  logic [1:0]              wr_size,
  input  logic                    wr_hi,
  input  logic [63:0]             wr_data,
  input  logic [$clog2(REGS)-1:0] ra_idx,
  input  logic [1:0]              ra_size,
  input  logic                    ra_hi,
  output logic [63:0]             ra_data,
  input  logic [$clog2(REGS)-1:0] rb_idx,
  input  logic [1:0]              rb_size,
  input  logic                    rb_hi,
  output logic [63:0]             rb_data
);
  localparam int IW = $clog2(REGS);

  logic [63:0] regs [REGS];
  logic [63:0] cur, nxt;
  logic        w_hi;

  function automatic logic [63:0] view(input logic [63:0] r, input logic [1:0] sz, input logic hi);
    case (sz)
      2'd3:    view = r;
      2'd2:    view = {32'h0, r[31:0]};
      2'd1:    view = {48'h0, r[15:0]};
      default: view = hi ? {56'h0, r[15:8]} : {56'h0, r[7:0]};
    endcase
  endfunction

  assign cur  = regs[wr_idx];
  assign w_hi = wr_hi && (wr_idx < IW'(HI_REGS));

  always_comb begin
    case (wr_size)
      2'd3:    nxt = wr_data;
      2'd2:    nxt = {32'h0, wr_data[31:0]};
      2'd1:    nxt = {cur[63:16], wr_data[15:0]};
      default: nxt = w_hi ? {cur[63:16], wr_data[7:0], cur[7:0]}
                          : {cur[63:8], wr_data[7:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= nxt;
    end
  end

  assign ra_data = view(regs[ra_idx], ra_size, ra_hi && (ra_idx < IW'(HI_REGS)));
  assign rb_data = view(regs[rb_idx], rb_size, rb_hi && (rb_idx < IW'(HI_REGS)));
endmodule

// File: rtl/regfile_pw_chk.sv
module regfile_pw_chk #(
  parameter int REGS    = 16,
  parameter int HI_REGS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [$clog2(REGS)-1:0] wr_idx,
  input logic [1:0]              wr_size,
  input logic                    wr_hi,
  input logic [63:0]             wr_data,
  input logic [$clog2(REGS)-1:0] ra_idx,
  input logic [1:0]              ra_size,
  input logic                    ra_hi,
  input logic [63:0]             ra_data,
  input logic [$clog2(REGS)-1:0] rb_idx,
  input logic [1:0]              rb_size,
  input logic                    rb_hi,
  input logic [63:0]             rb_data
);
  localparam int IW = $clog2(REGS);

  logic full_a;
  assign full_a = wr_en && ra_idx == wr_idx && ra_size == 2'd3 && !ra_hi;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rst || ra_data == 64'h0));

  p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
    (full_a && wr_size == 2'd3) |=>
      (ra_idx != $past(ra_idx) || ra_size != 2'd3 || ra_data == $past(wr_data)));

  p_word_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (full_a && wr_size == 2'd2) |=>
      (ra_idx != $past(ra_idx) || ra_size != 2'd3 || ra_data == {32'h0, $past(wr_data[31:0])}));

  p_half_merge_r4: assert property (@(posedge clk) disable iff (rst)
    (full_a && wr_size == 2'd1) |=>
      (ra_idx != $past(ra_idx) || ra_size != 2'd3 ||
       ra_data == {$past(ra_data[63:16]), $past(wr_data[15:0])}));

  p_high_byte_merge_r6: assert property (@(posedge clk) disable iff (rst)
    (full_a && wr_size == 2'd0 && wr_hi && wr_idx < IW'(HI_REGS)) |=>
      (ra_idx != $past(ra_idx) || ra_size != 2'd3 ||
       ra_data == {$past(ra_data[63:16]), $past(wr_data[7:0]), $past(ra_data[7:0])}));

  p_hi_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (full_a && wr_size == 2'd0 && wr_idx >= IW'(HI_REGS)) |=>
      (ra_idx != $past(ra_idx) || ra_size != 2'd3 ||
       ra_data == {$past(ra_data[63:8]), $past(wr_data[7:0])}));

  p_zero_ext_r8: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'd0 -> ra_data[63:8] == 56'h0) && (ra_size == 2'd1 -> ra_data[63:16] == 48'h0) &&
    (rb_size == 2'd2 -> rb_data[63:32] == 32'h0) && (rb_size == 2'd0 -> rb_data[63:8] == 56'h0));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!($stable(ra_idx) && $stable(ra_size) && $stable(ra_hi)) || $stable(ra_data)));

  p_port_b_stable_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!($stable(rb_idx) && $stable(rb_size) && $stable(rb_hi)) || $stable(rb_data)));
endmodule

bind regfile_pw regfile_pw_chk #(.REGS(REGS), .HI_REGS(HI_REGS)) u_chk (.*);

// File: tb/sim_regfile_pw.sv
module sim_regfile_pw;
  logic        clk = 0, rst = 1, wr_en = 0, wr_hi = 0, ra_hi = 0, rb_hi = 0;
  logic [3:0]  wr_idx = 0, ra_idx = 0, rb_idx = 0;
  logic [1:0]  wr_size = 0, ra_size = 0, rb_size = 0;
  logic [63:0] wr_data = 0, ra_data, rb_data;
  logic [63:0] model [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regfile_pw u0 (.*);

  function automatic logic [63:0] exp_rd(input int idx, input int sz, input bit hi);
    int off = (hi && sz == 0 && idx < 4) ? 8 : 0;
    logic [63:0] mask = (sz == 3) ? '1 : ((64'h1 << (8 << sz)) - 1);
    return (model[idx] >> off) & mask;
  endfunction

  task automatic apply_write();
    int lo = (wr_hi && wr_size == 0 && wr_idx < 4) ? 1 : 0;
    int n = 1 << wr_size;
    logic [63:0] v = model[wr_idx];
    for (int b = 0; b < 8; b++) begin
      if (b >= lo && b < lo + n) v[b*8 +: 8] = wr_data[(b-lo)*8 +: 8];
      else if (wr_size == 2 && b >= 4) v[b*8 +: 8] = 8'h0;
    end
    model[wr_idx] = v;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    #1;
    check(tag, ra_data, exp_rd(ra_idx, ra_size, ra_hi));
    check(tag, rb_data, exp_rd(rb_idx, rb_size, rb_hi));
    @(posedge clk);
    if (rst) for (int i = 0; i < 16; i++) model[i] = '0;
    else if (wr_en) apply_write();
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int sz, input bit hi, input logic [63:0] d);
    wr_en = 1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_hi = hi; wr_data = d;
  endtask

  task automatic rda(input int idx, input int sz, input bit hi);
    ra_idx = 4'(idx); ra_size = 2'(sz); ra_hi = hi;
  endtask

  task automatic rdb(input int idx, input int sz, input bit hi);
    rb_idx = 4'(idx); rb_size = 2'(sz); rb_hi = hi;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    @(negedge clk);
    // R1: a write during reset is dropped, and the file reads zero
    wr(3, 3, 0, 64'hdead_beef_0000_1111);
    step("R1");
    step("R1");
    rst = 0;
    wr_en = 0;
    for (int i = 0; i < 16; i++) begin
      rda(i, 3, 0); rdb(15 - i, 3, 0);
      step("R1");
    end
    // R2: full write, then full read
    wr(0, 3, 0, 64'h0123_4567_89ab_cdef); rda(0, 3, 0); step("R2");
    wr_en = 0; step("R2");
    // R3: word write clears the upper half
    wr(0, 2, 0, 64'hffff_ffff_1122_3344); step("R3");
    wr_en = 0; step("R3");
    // R4: half write keeps bits 63:16
    wr(1, 3, 0, 64'haaaa_bbbb_cccc_dddd); rda(1, 3, 0); step("R4");
    wr(1, 1, 0, 64'h1111_2222_3333_5566); step("R4");
    wr_en = 0; step("R4");
    // R5: low byte write
    wr(1, 0, 0, 64'hffff_ffff_ffff_ff77); step("R5");
    wr_en = 0; rdb(1, 0, 0); step("R5");
    // R6: high byte write and read on register 2
    wr(2, 3, 0, 64'h8877_6655_4433_2211); rda(2, 3, 0); step("R6");
    wr(2, 0, 1, 64'h0000_0000_0000_00c3); rdb(2, 0, 1); step("R6");
    wr_en = 0; step("R6");
    // R7: high select on registers above 3 and on wider sizes
    wr(5, 3, 0, 64'h5555_5555_5555_5555); rda(5, 3, 0); rdb(5, 0, 1); step("R7");
    wr(5, 0, 1, 64'h0000_0000_0000_00e1); step("R7");
    wr(2, 1, 1, 64'h0000_0000_0000_9abc); rdb(2, 1, 1); step("R7");
    wr_en = 0; rda(2, 3, 0); step("R7");
    // R8: zero-extension on every size
    for (int s = 0; s < 4; s++) begin
      rda(0, s, 0); rdb(1, s, 0); step("R8");
    end
    // R9: same-cycle read sees the old value
    wr(6, 3, 0, 64'h0606_0606_0606_0606); rda(6, 3, 0); step("R9");
    wr(6, 3, 0, 64'h7070_7070_7070_7070); step("R9");
    wr_en = 0; step("R9");
    // R10: register 4 behaves normally
    wr(4, 3, 0, 64'h4444_0000_4444_0000); rda(4, 3, 0); step("R10");
    wr(4, 0, 1, 64'h0000_0000_0000_0042); rdb(4, 0, 0); step("R10");
    wr_en = 0; step("R10");
    // R11: mixed random traffic on both ports
    for (int k = 0; k < 3000; k++) begin
      wr_en   = ($urandom % 3) != 0;
      wr_idx  = 4'($urandom);
      wr_size = 2'($urandom);
      wr_hi   = 1'($urandom);
      wr_data = {$urandom, $urandom};
      if ($urandom % 2) rda(wr_idx, 3, 0); else rda($urandom % 16, $urandom % 4, 1'($urandom));
      if ($urandom % 4 != 0) rdb($urandom % 16, $urandom % 4, 1'($urandom));
      step("R11");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule